// File: doc/BRIEF.md
# Strobed External Bus Cycle Sequencer

This block is a bus master for an asynchronous external peripheral bus. The bus has an address strobe, a data strobe, a read/write line and an acknowledge returned by the peripheral. Requests come in on an internal interface that carries an address, write data and a direction flag. The block then runs one bus cycle. It finishes by returning a single-clock completion pulse, together with the read data when the cycle was a read.

Every cycle steps through eight bus states, named S0 to S7. Each state lasts a fixed number of system clocks, two by default. The strobes and the read/write line change only at set state boundaries. The acknowledge is asynchronous, so it passes through a synchronizer. It is sampled one full clock before the end of S4 and before the end of each wait state. When it has not arrived, the sequencer adds whole wait states (state SW) until it has. The external data bus is shown as an output, an input and an output enable, so that a pad ring can build the tri-state driver from them.

The states and transitions are as follows:
- IDLE goes to S0 on an accepted request.
- S0 goes to S1, S1 to S2, S2 to S3 and S3 to S4, each at the end of the state.
- At the end of S4 or SW, the next state is S5 if the acknowledge was seen and SW if it was not.
- S5 goes to S6, S6 to S7, and S7 returns to IDLE.

Top module: `strobe_bus_seq`

## Requirements
- R1: After reset the outputs are in the idle state: `as_n`=1, `ds_n`=1, `bus_rw`=1 (1 means read), `bus_doe`=0, `done`=0 and `req_ready`=1.
- R2: Each of the states S0 to S7 lasts exactly two clocks. Take the request as accepted at clock edge 0. With no wait states, `done` is high in the clock after edge 16.
- R3: `bus_addr` shows the accepted address from the start of S1 until the end of S7, and it does not change while `as_n` is low.
- R4: `as_n` is low in S2, S3, S4, every wait state, S5 and S6. It goes high on entry to S7, together with `ds_n`.
- R5: `ds_n` is low in S4, every wait state, S5 and S6, and at no other time.
- R6: In a write cycle `bus_rw` is 0 from the start of S2 to the end of S7. In every other state it is 1, including S0 of a write that follows a write. A read cycle keeps `bus_rw` at 1 throughout.
- R7: `bus_doe` is 1 only in a write cycle, and only from S3 through S6. `bus_dout` carries the write data while it is 1.
- R8: `dtack_n` is active low and passes through a two-flop synchronizer. It is sampled one clock before the end of S4 and before the end of each wait state. Each miss adds one wait state of two clocks. If `dtack_n` first goes low after clock edge k (edges counted from acceptance), the number of wait states is 0 when k ≤ 6 and ceil((k−6)/2) otherwise.
- R9: A read latches `bus_din` at the clock edge that enters S7. `rdata` holds that value while `done` is high.
- R10: `done` is a one-clock pulse. A request is taken only when `req_ready` is 1. A `req_valid` raised during a cycle is ignored: it starts no later cycle and does not change `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| req_ready | output | 1 | Sequencer is idle and can take a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Read data, valid while done is high |
| bus_addr | output | AW | External address bus |
| bus_dout | output | DW | External data bus, driven value |
| bus_doe | output | 1 | Enable for the external data bus driver |
| bus_din | input | DW | External data bus, received value |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| dtack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |

## Verification
The assertions put no condition on the request inputs, because the sequencer reads them only in IDLE. They also put none on `dtack_n`, because the synchronizer and the sample point take in any timing of the acknowledge. They do rely on the acknowledge being removed before the next cycle reaches S4. Otherwise a stale acknowledge would be counted, which is correct behaviour but would spoil the wait-state count the bench expects. The bench therefore drives every input on the falling clock edge. It asserts `dtack_n` only at a chosen clock within a cycle and releases it after `done`. It places `bus_din` only for the S6 window of reads.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S0,
        ST_S1,
        ST_S2,
        ST_S3,
        ST_S4,
        ST_SW,
        ST_S5,
        ST_S6,
        ST_S7
    } bus_state_t;
endpackage

// File: rtl/sbs_ack_sync.sv
module sbs_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic seen
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_n};
    end

    assign seen = !chain[STAGES-1];
endmodule

// File: rtl/sbs_phase_ctr.sv
module sbs_phase_ctr #(
    parameter int CLKS_PER_STATE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last,
    output logic penult
);
    localparam int CW = (CLKS_PER_STATE > 1) ? $clog2(CLKS_PER_STATE) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(CLKS_PER_STATE - 1);
    localparam logic [CW-1:0] PEN_V  = CW'(CLKS_PER_STATE - 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (last)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assign last   = (cnt == LAST_V);
    assign penult = (cnt == PEN_V);
endmodule

// File: rtl/strobe_bus_seq.sv
module strobe_bus_seq
    import sbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CLKS_PER_STATE = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] bus_din,
    output logic          as_n,
    output logic          ds_n,
    output logic          bus_rw,
    input  logic          dtack_n
);
    bus_state_t state, state_nx;
    logic          st_last, st_pen, ack_s, ack_q, wr_q;
    logic [AW-1:0] addr_q;

    sbs_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_n(dtack_n), .seen(ack_s)
    );

    sbs_phase_ctr #(.CLKS_PER_STATE(CLKS_PER_STATE)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE),
        .last(st_last), .penult(st_pen)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_S0;
            ST_S0:   if (st_last) state_nx = ST_S1;
            ST_S1:   if (st_last) state_nx = ST_S2;
            ST_S2:   if (st_last) state_nx = ST_S3;
            ST_S3:   if (st_last) state_nx = ST_S4;
            ST_S4, ST_SW:
                     if (st_last) state_nx = ack_q ? ST_S5 : ST_SW;
            ST_S5:   if (st_last) state_nx = ST_S6;
            ST_S6:   if (st_last) state_nx = ST_S7;
            ST_S7:   if (st_last) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            bus_addr <= '0;
            bus_dout <= '0;
            rdata    <= '0;
            ack_q    <= 1'b0;
            done     <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_S7) && st_last;
            if (state == ST_IDLE) begin
                ack_q <= 1'b0;
                if (req_valid) begin
                    wr_q     <= req_write;
                    addr_q   <= req_addr;
                    bus_dout <= req_wdata;
                end
            end
            if (state == ST_S0 && st_last) bus_addr <= addr_q;
            if ((state == ST_S4 || state == ST_SW) && st_pen) ack_q <= ack_s;
            if (state == ST_S6 && st_last && !wr_q) rdata <= bus_din;
        end
    end

    // strobe and direction decode
    always_comb begin
        as_n    = 1'b1;
        ds_n    = 1'b1;
        bus_rw  = 1'b1;
        bus_doe = 1'b0;
        unique case (state)
            ST_IDLE, ST_S0, ST_S1: ;
            ST_S2: begin
                as_n   = 1'b0;
                bus_rw = !wr_q;
            end
            ST_S3: begin
                as_n    = 1'b0;
                bus_rw  = !wr_q;
                bus_doe = wr_q;
            end
            ST_S4, ST_SW, ST_S5, ST_S6: begin
                as_n    = 1'b0;
                ds_n    = 1'b0;
                bus_rw  = !wr_q;
                bus_doe = wr_q;
            end
            ST_S7: bus_rw = !wr_q;
            default: ;
        endcase
    end

    assign req_ready = (state == ST_IDLE);

    AST_DS_WITHIN_AS: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> !as_n); // R5
    AST_STROBES_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_n) |-> $rose(ds_n)); // R4
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && $past(!as_n)) |-> $stable(bus_addr)); // R3
    AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> !bus_rw); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !done || $past(!req_ready)); // R10
endmodule

// File: tb/strobe_bus_seq_test.sv
module strobe_bus_seq_test;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, bus_din = '0;
    logic          dtack_n = 1'b1;
    logic          req_ready, done, bus_doe, as_n, ds_n, bus_rw;
    logic [DW-1:0] rdata, bus_dout;
    logic [AW-1:0] bus_addr;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    strobe_bus_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .as_n(as_n), .ds_n(ds_n),
        .bus_rw(bus_rw), .dtack_n(dtack_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One bus cycle. ack_at: clock after which dtack_n goes low (-1 = low from the start).
    task automatic run_cycle(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic [DW-1:0] rd, input int ack_at, input bit poke_busy);
        int w, s, n;
        bit strobe_ok = 1'b1, seen_done = 1'b0;
        logic [3:0] exp_v, act_v;
        w = (ack_at <= 6) ? 0 : (ack_at - 5) / 2;
        if (ack_at < 0) dtack_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        n = 0;
        while (n < 16 + 2*w + 1 && !seen_done) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (poke_busy && n == 5) begin
                req_valid = 1'b1; req_addr = ~a; req_write = ~wr;
            end
            if (n == ack_at) dtack_n = 1'b0;
            if (n == 12 + 2*w) bus_din = rd;
            if (n == 14 + 2*w) bus_din = ~rd;
            if (n < 10) s = n / 2;
            else if (n < 10 + 2*w) s = 8;
            else s = (n - 2*w) / 2;
            if (n < 16 + 2*w) begin
                exp_v[3] = !((s >= 2 && s <= 6) || s == 8);
                exp_v[2] = !((s >= 4 && s <= 6) || s == 8);
                exp_v[1] = !(wr && s >= 2);
                exp_v[0] = wr && ((s >= 3 && s <= 6) || s == 8);
                act_v = {as_n, ds_n, bus_rw, bus_doe};
                if (act_v != exp_v) begin
                    strobe_ok = 1'b0;
                    check(1'b0, "R4/R5/R6/R7", $sformatf("strobes {as,ds,rw,oe} clk %0d", n),
                          act_v, exp_v);
                end
                if (s >= 1 && bus_addr != a) begin
                    strobe_ok = 1'b0;
                    check(1'b0, "R3", $sformatf("bus_addr clk %0d", n), bus_addr, a);
                end
                if (wr && bus_doe && bus_dout != d) begin
                    strobe_ok = 1'b0;
                    check(1'b0, "R7", "bus_dout", bus_dout, d);
                end
                if (done) begin
                    check(1'b0, "R2/R8", $sformatf("early done clk %0d", n), n, 16 + 2*w);
                    seen_done = 1'b1;
                end
                if (n == 5 && poke_busy)
                    check(req_ready == 1'b0, "R10", "req_ready while busy", req_ready, 0);
            end else begin
                seen_done = done;
            end
            n++;
        end
        check(strobe_ok, "R3 R4 R5 R6 R7", "strobe schedule", strobe_ok, 1);
        check(seen_done && n == 16 + 2*w + 1, "R2 R8", "cycles to done", n - 1, 16 + 2*w);
        if (!wr) check(rdata == rd, "R9", "read data", rdata, rd);
        dtack_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R10", "done pulse width", done, 0);
        check(req_ready == 1'b1 && bus_rw == 1'b1, "R6 R10", "idle after cycle",
              {req_ready, bus_rw}, 2'b11);
    endtask

    task automatic test_reset();
        check({as_n, ds_n, bus_rw, bus_doe, done, req_ready} == 6'b111001, "R1",
              "reset outputs", {as_n, ds_n, bus_rw, bus_doe, done, req_ready}, 6'b111001);
    endtask

    task automatic test_ignored_request();
        bit quiet = 1'b1;
        run_cycle(1'b1, 16'h4242, 8'h17, 8'h00, -1, 1'b1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!as_n || !req_ready) quiet = 1'b0;
        end
        check(quiet, "R10", "no cycle from request raised while busy", quiet, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_cycle(1'b1, 16'h1234, 8'hA5, 8'h00, -1, 1'b0);  // R2 write, no wait
        run_cycle(1'b1, 16'h0F0F, 8'h3C, 8'h00, -1, 1'b0);  // R6 write after write
        run_cycle(1'b0, 16'hBEEF, 8'h00, 8'h5A, -1, 1'b0);  // R9 read, no wait
        run_cycle(1'b0, 16'h0001, 8'h00, 8'hC3, 6, 1'b0);   // R8 late edge, still no wait
        run_cycle(1'b0, 16'h8000, 8'h00, 8'h96, 7, 1'b0);   // R8 one wait
        run_cycle(1'b1, 16'h00FF, 8'h81, 8'h00, 8, 1'b0);   // R8 one wait
        run_cycle(1'b1, 16'h7777, 8'h42, 8'h00, 9, 1'b0);   // R8 two waits
        run_cycle(1'b0, 16'hABCD, 8'h00, 8'h69, 14, 1'b0);  // R8 four waits
        test_ignored_request();                             // R10
        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
        if (!finished) check(1'b0, "watchdog", "run ended early", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule